// File: doc/BRIEF.md
# Signed Charge Pulse Accumulator

This block sits on the host side of a charge-metering front end. The front end pulls an active-low interrupt line low each time a fixed unit of charge has passed. At the same moment it latches a polarity line. The block answers every interrupt. It reads the polarity and emits a one-cycle strobe on either a charge output or a discharge output. It then drives an active-low clear output for a programmed number of cycles, which releases the interrupt and the polarity latch.

Each strobe also moves a signed tally that is kept as a chain of decimal digits. A charge strobe adds one unit and a discharge strobe removes one. With suitable scaling, 10,000 units make one ampere-hour, so a display can show the digits directly. The tally stops at zero and at all nines rather than wrapping, and a sticky flag records the attempt to pass either end. A deadline counter raises a sticky overrun flag when the interrupt line stays low for too long. A monitor-enable input marks the periods when the front end is shut down or starting up. While it is low, the block ignores the interrupt and polarity lines. Software can preset the tally to a known capacity or clear it.

Top module: `coulomb_tally`

## Requirements
- R1: After reset the tally reads zero, `clr_n` is high, both strobes are low and `sat_high`, `sat_low` and `overrun` are low.
- R2: With `mon_ok` high and the block idle, a clock edge that sees `irq_n` low samples `pol`. For `pol`=1 it gives exactly one one-cycle `chg_pulse` in the next cycle, and for `pol`=0 exactly one one-cycle `dis_pulse`. The two strobes are never high together, and later changes of `pol` do not affect that interrupt.
- R3: `clr_n` goes low in the same cycle as the strobe and stays low for exactly CLR_CYC consecutive cycles.
- R4: Only one strobe is produced per interrupt, even when `irq_n` stays low after the clear has ended. The next interrupt is accepted only after `irq_n` has been seen high.
- R5: `tally_bcd` holds DIGITS BCD digits of 4 bits each, with the least significant digit in bits [3:0]. A charge strobe increments the tally one cycle later, and a digit going from 9 to 0 carries into the next digit.
- R6: A discharge strobe decrements the tally one cycle later, and a digit going from 0 to 9 borrows from the next digit.
- R7: A charge strobe while every digit is 9 leaves the tally unchanged and sets `sat_high`. `sat_high` stays set until a preset or clear.
- R8: A discharge strobe while the tally is zero leaves it at zero and sets `sat_low`. `sat_low` stays set until a preset or clear.
- R9: `overrun` rises after DEADLINE_CYC consecutive clock edges that see `irq_n` low with `mon_ok` high, and not earlier. It stays set until `tally_clr`.
- R10: While `mon_ok` is low, `irq_n` and `pol` have no effect: no strobe, `clr_n` stays high, the tally is unchanged and the deadline does not run.
- R11: `preset_en` loads `preset_val` into the tally and clears `sat_high` and `sat_low`. `tally_clr` zeroes the tally and clears all three flags. `tally_clr` has priority over `preset_en`, and `preset_en` has priority over a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_ok | input | 1 | High while the front end is enabled and settled |
| irq_n | input | 1 | Active-low charge-unit interrupt, synchronous |
| pol | input | 1 | Latched polarity: 1 charge, 0 discharge |
| tally_clr | input | 1 | Synchronous clear of the tally and all flags |
| preset_en | input | 1 | Synchronous load of `preset_val` |
| preset_val | input | 4*DIGITS | BCD preset value |
| clr_n | output | 1 | Active-low clear to the front end |
| chg_pulse | output | 1 | One-cycle charge strobe |
| dis_pulse | output | 1 | One-cycle discharge strobe |
| tally_bcd | output | 4*DIGITS | Accumulated tally in BCD |
| sat_high | output | 1 | Sticky: increment attempted at all nines |
| sat_low | output | 1 | Sticky: decrement attempted at zero |
| overrun | output | 1 | Sticky: interrupt left pending past the deadline |

## Verification
A broken carry or borrow stage shows up in `tally_bcd` one cycle after the strobe that crosses a decade boundary. The bench therefore steps the tally across single and multi-digit boundaries and across both saturation ends. A service state machine stuck in the wrong state shows at once as a second strobe, a missing strobe, or a `clr_n` width that differs from CLR_CYC. A deadline counter that is off by one moves the rise of `overrun` by one cycle, so the bench samples on both sides of that edge.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;

    typedef enum logic [1:0] {
        SVC_IDLE    = 2'd0,
        SVC_CLEAR   = 2'd1,
        SVC_RELEASE = 2'd2
    } svc_state_e;

endpackage

// File: rtl/bcd_stage.sv
module bcd_stage (
    input  logic [3:0] digit_i,
    input  logic       inc_i,
    input  logic       dec_i,
    output logic [3:0] digit_o,
    output logic       carry_o,
    output logic       borrow_o
);

    always_comb begin
        digit_o  = digit_i;
        carry_o  = 1'b0;
        borrow_o = 1'b0;
        if (inc_i) begin
            if (digit_i >= 4'd9) begin
                digit_o = 4'd0;
                carry_o = 1'b1;
            end else begin
                digit_o = digit_i + 4'd1;
            end
        end else if (dec_i) begin
            if (digit_i == 4'd0) begin
                digit_o  = 4'd9;
                borrow_o = 1'b1;
            end else begin
                digit_o = digit_i - 4'd1;
            end
        end
    end

endmodule

// File: rtl/bcd_accum.sv
module bcd_accum #(
    parameter int DIGITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_i,
    input  logic                dn_i,
    input  logic                clr_i,
    input  logic                load_i,
    input  logic [4*DIGITS-1:0] load_val_i,
    output logic [4*DIGITS-1:0] digits_o,
    output logic                over_o,
    output logic                under_o
);

    localparam int W = 4 * DIGITS;

    typedef struct packed {
        logic [W-1:0] digits;
        logic         over;
        logic         under;
    } acc_t;

    acc_t q, d;

    logic [DIGITS:0] inc_c;
    logic [DIGITS:0] dec_c;
    logic [W-1:0]    nxt;

    assign inc_c[0] = up_i;
    assign dec_c[0] = dn_i & ~up_i;

    // One decade per stage; carry and borrow ripple upward.
    genvar i;
    generate
        for (i = 0; i < DIGITS; i++) begin : g_dig
            bcd_stage u_stage (
                .digit_i  (q.digits[4*i +: 4]),
                .inc_i    (inc_c[i]),
                .dec_i    (dec_c[i]),
                .digit_o  (nxt[4*i +: 4]),
                .carry_o  (inc_c[i+1]),
                .borrow_o (dec_c[i+1])
            );
        end
    endgenerate

    always_comb begin
        d = q;
        if (clr_i) begin
            d.digits = '0;
            d.over   = 1'b0;
            d.under  = 1'b0;
        end else if (load_i) begin
            d.digits = load_val_i;
            d.over   = 1'b0;
            d.under  = 1'b0;
        end else if (up_i) begin
            // A carry out of the top decade means all nines: hold.
            if (inc_c[DIGITS]) d.over = 1'b1;
            else               d.digits = nxt;
        end else if (dn_i) begin
            if (dec_c[DIGITS]) d.under = 1'b1;
            else               d.digits = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign digits_o = q.digits;
    assign over_o   = q.over;
    assign under_o  = q.under;

endmodule

// File: rtl/irq_service.sv
module irq_service
    import coulomb_pkg::*;
#(
    parameter int CLR_CYC      = 20,
    parameter int DEADLINE_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_ok_i,
    input  logic irq_n_i,
    input  logic pol_i,
    input  logic ovr_clr_i,
    output logic clr_n_o,
    output logic chg_o,
    output logic dis_o,
    output logic overrun_o
);

    localparam int CW = $clog2(CLR_CYC + 1);
    localparam int DW = $clog2(DEADLINE_CYC + 1);
    localparam logic [CW-1:0] CLR_LOAD = CW'(CLR_CYC - 1);
    localparam logic [DW-1:0] DL_LAST  = DW'(DEADLINE_CYC - 1);

    typedef struct packed {
        svc_state_e    state;
        logic [CW-1:0] clr_cnt;
        logic [DW-1:0] dl_cnt;
        logic          clr_n;
        logic          chg;
        logic          dis;
        logic          overrun;
    } svc_t;

    svc_t q, d;

    always_comb begin
        d     = q;
        d.chg = 1'b0;
        d.dis = 1'b0;
        if (!mon_ok_i) begin
            d.state   = SVC_IDLE;
            d.clr_n   = 1'b1;
            d.clr_cnt = '0;
            d.dl_cnt  = '0;
        end else begin
            unique case (q.state)
                SVC_IDLE: begin
                    if (!irq_n_i) begin
                        d.chg     = pol_i;
                        d.dis     = ~pol_i;
                        d.clr_n   = 1'b0;
                        d.clr_cnt = CLR_LOAD;
                        d.state   = SVC_CLEAR;
                    end
                end
                SVC_CLEAR: begin
                    if (q.clr_cnt == '0) begin
                        d.clr_n = 1'b1;
                        d.state = SVC_RELEASE;
                    end else begin
                        d.clr_cnt = q.clr_cnt - 1'b1;
                    end
                end
                SVC_RELEASE: begin
                    if (irq_n_i) d.state = SVC_IDLE;
                end
                default: d.state = SVC_IDLE;
            endcase

            // Service deadline: consecutive edges with the line pending.
            if (irq_n_i) begin
                d.dl_cnt = '0;
            end else if (q.dl_cnt == DL_LAST) begin
                d.overrun = 1'b1;
            end else begin
                d.dl_cnt = q.dl_cnt + 1'b1;
            end
        end
        if (ovr_clr_i) d.overrun = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= SVC_IDLE;
            q.clr_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clr_n_o   = q.clr_n;
    assign chg_o     = q.chg;
    assign dis_o     = q.dis;
    assign overrun_o = q.overrun;

endmodule

// File: rtl/coulomb_tally.sv
module coulomb_tally #(
    parameter int DIGITS       = 5,
    parameter int CLR_CYC      = 20,
    parameter int DEADLINE_CYC = 50000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mon_ok,
    input  logic                irq_n,
    input  logic                pol,
    input  logic                tally_clr,
    input  logic                preset_en,
    input  logic [4*DIGITS-1:0] preset_val,
    output logic                clr_n,
    output logic                chg_pulse,
    output logic                dis_pulse,
    output logic [4*DIGITS-1:0] tally_bcd,
    output logic                sat_high,
    output logic                sat_low,
    output logic                overrun
);

    irq_service #(
        .CLR_CYC      (CLR_CYC),
        .DEADLINE_CYC (DEADLINE_CYC)
    ) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_ok_i  (mon_ok),
        .irq_n_i   (irq_n),
        .pol_i     (pol),
        .ovr_clr_i (tally_clr),
        .clr_n_o   (clr_n),
        .chg_o     (chg_pulse),
        .dis_o     (dis_pulse),
        .overrun_o (overrun)
    );

    bcd_accum #(
        .DIGITS (DIGITS)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_i       (chg_pulse),
        .dn_i       (dis_pulse),
        .clr_i      (tally_clr),
        .load_i     (preset_en),
        .load_val_i (preset_val),
        .digits_o   (tally_bcd),
        .over_o     (sat_high),
        .under_o    (sat_low)
    );

endmodule

// File: rtl/coulomb_tally_chk.sv
module coulomb_tally_chk #(
    parameter int DIGITS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mon_ok,
    input logic                tally_clr,
    input logic                preset_en,
    input logic                clr_n,
    input logic                chg_pulse,
    input logic                dis_pulse,
    input logic [4*DIGITS-1:0] tally_bcd,
    input logic                sat_high,
    input logic                sat_low,
    input logic                overrun
);

    // R2: never both strobes
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chg_pulse, dis_pulse}));

    // R2: strobes last one cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pulse || dis_pulse) |=> !(chg_pulse || dis_pulse));

    // R3: clear is low while a strobe is out
    a_r3_clr_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pulse || dis_pulse) |-> !clr_n);

    // R5: a charge strobe moves the tally or marks saturation
    a_r5_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pulse && !tally_clr && !preset_en) |=>
            ((tally_bcd != $past(tally_bcd)) || sat_high));

    // R7: high saturation flag is sticky
    a_r7_high_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_high && !tally_clr && !preset_en) |=> sat_high);

    // R8: low saturation flag is sticky
    a_r8_low_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_low && !tally_clr && !preset_en) |=> sat_low);

    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !tally_clr) |=> overrun);

    // R10: quiet while the monitor is off
    a_r10_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_ok |=> (clr_n && !chg_pulse && !dis_pulse));

    // R11: clear empties tally and flags
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tally_clr |=> ((tally_bcd == '0) && !sat_high && !sat_low && !overrun));

endmodule

bind coulomb_tally coulomb_tally_chk #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_ok    (mon_ok),
    .tally_clr (tally_clr),
    .preset_en (preset_en),
    .clr_n     (clr_n),
    .chg_pulse (chg_pulse),
    .dis_pulse (dis_pulse),
    .tally_bcd (tally_bcd),
    .sat_high  (sat_high),
    .sat_low   (sat_low),
    .overrun   (overrun)
);

// File: tb/coulomb_tally_tb.sv
module coulomb_tally_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIGITS     = 5;
    localparam int CLR_CYC    = 4;
    localparam int DL_CYC     = 30;
    localparam int MAXV       = 99999;

    // op: 0 charge, 1 discharge, 2 preset ARG, 3 clear
    localparam int NV = 14;
    localparam int OP [NV]  = '{2, 0, 1, 2, 1, 2, 0, 0, 3, 1, 0, 2, 0, 1};
    localparam int ARG[NV]  = '{9, 0, 0, 100, 0, 99998, 0, 0, 0, 0, 0, 12345, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_ok = 1'b1;
    logic irq_n = 1'b1;
    logic pol = 1'b0;
    logic tally_clr = 1'b0;
    logic preset_en = 1'b0;
    logic [4*DIGITS-1:0] preset_val = '0;
    logic clr_n, chg_pulse, dis_pulse, sat_high, sat_low, overrun;
    logic [4*DIGITS-1:0] tally_bcd;

    int checks = 0;
    int errors = 0;
    int cnt_chg = 0, cnt_dis = 0, clr_low_total = 0;
    int cur_w = 0, last_w = 0;
    int exp_val = 0;
    logic exp_hi = 1'b0, exp_lo = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coulomb_tally #(.DIGITS(DIGITS), .CLR_CYC(CLR_CYC), .DEADLINE_CYC(DL_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mon_ok(mon_ok), .irq_n(irq_n), .pol(pol),
        .tally_clr(tally_clr), .preset_en(preset_en), .preset_val(preset_val),
        .clr_n(clr_n), .chg_pulse(chg_pulse), .dis_pulse(dis_pulse),
        .tally_bcd(tally_bcd), .sat_high(sat_high), .sat_low(sat_low), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (chg_pulse) cnt_chg++;
            if (dis_pulse) cnt_dis++;
            if (!clr_n) begin
                cur_w++;
                clr_low_total++;
            end else if (cur_w > 0) begin
                last_w = cur_w;
                cur_w  = 0;
            end
        end
    end

    function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
        logic [4*DIGITS-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic fire(input logic p);
        @(negedge clk);
        pol   = p;
        irq_n = 1'b0;
        do @(negedge clk); while (clr_n);
        irq_n = 1'b1;
        pol   = ~p;             // later polarity changes must not matter
        do @(negedge clk); while (!clr_n);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_tally(input string req);
        check(req, "tally_bcd", tally_bcd, to_bcd(exp_val));
        check(req, "sat_high", sat_high, exp_hi);
        check(req, "sat_low", sat_low, exp_lo);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        int c0, d0, w0;
        string rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "tally_bcd", tally_bcd, 0);
        check("R1", "clr_n", clr_n, 1);
        check("R1", "strobes", {chg_pulse, dis_pulse}, 0);
        check("R1", "flags", {sat_high, sat_low, overrun}, 0);

        for (int v = 0; v < NV; v++) begin
            c0 = cnt_chg;
            d0 = cnt_dis;
            case (OP[v])
                0: begin
                    rq = (exp_val == MAXV) ? "R7" : "R5";
                    fire(1'b1);
                    if (exp_val == MAXV) exp_hi = 1'b1; else exp_val++;
                    check("R2", "charge strobes", cnt_chg - c0, 1);
                    check("R2", "discharge strobes", cnt_dis - d0, 0);
                    check("R3", "clr width", last_w, CLR_CYC);
                end
                1: begin
                    rq = (exp_val == 0) ? "R8" : "R6";
                    fire(1'b0);
                    if (exp_val == 0) exp_lo = 1'b1; else exp_val--;
                    check("R2", "discharge strobes", cnt_dis - d0, 1);
                    check("R2", "charge strobes", cnt_chg - c0, 0);
                    check("R3", "clr width", last_w, CLR_CYC);
                end
                2: begin
                    rq = "R11";
                    @(negedge clk);
                    preset_val = to_bcd(ARG[v]);
                    preset_en  = 1'b1;
                    @(negedge clk);
                    preset_en  = 1'b0;
                    exp_val = ARG[v];
                    exp_hi  = 1'b0;
                    exp_lo  = 1'b0;
                end
                default: begin
                    rq = "R11";
                    @(negedge clk);
                    tally_clr = 1'b1;
                    @(negedge clk);
                    tally_clr = 1'b0;
                    exp_val = 0;
                    exp_hi  = 1'b0;
                    exp_lo  = 1'b0;
                end
            endcase
            check_tally(rq);
        end

        // R9 / R4: interrupt held low past the deadline
        c0 = cnt_chg;
        @(negedge clk);
        pol   = 1'b1;
        irq_n = 1'b0;
        repeat (DL_CYC - 1) @(negedge clk);
        check("R9", "overrun before deadline", overrun, 0);
        @(negedge clk);
        check("R9", "overrun at deadline", overrun, 1);
        check("R4", "strobes while held low", cnt_chg - c0, 1);
        irq_n = 1'b1;
        repeat (4) @(negedge clk);
        exp_val++;
        check("R9", "overrun sticky", overrun, 1);
        check_tally("R4");
        fire(1'b1);
        exp_val++;
        check("R4", "re-armed after release", cnt_chg - c0, 2);
        check_tally("R5");

        // R11: clear beats preset, and clears overrun
        @(negedge clk);
        tally_clr  = 1'b1;
        preset_en  = 1'b1;
        preset_val = to_bcd(777);
        @(negedge clk);
        tally_clr = 1'b0;
        preset_en = 1'b0;
        exp_val = 0;
        check_tally("R11");
        check("R11", "overrun cleared", overrun, 0);

        // R10: monitor off, erratic lines ignored
        @(negedge clk);
        preset_val = to_bcd(500);
        preset_en  = 1'b1;
        @(negedge clk);
        preset_en = 1'b0;
        exp_val = 500;
        c0 = cnt_chg;
        d0 = cnt_dis;
        w0 = clr_low_total;
        mon_ok = 1'b0;
        irq_n  = 1'b0;
        for (int k = 0; k < DL_CYC + 5; k++) begin
            @(negedge clk);
            pol = ~pol;
        end
        check("R10", "strobes while off", (cnt_chg - c0) + (cnt_dis - d0), 0);
        check("R10", "clr low cycles while off", clr_low_total - w0, 0);
        check("R10", "overrun while off", overrun, 0);
        check_tally("R10");
        irq_n = 1'b1;
        @(negedge clk);
        mon_ok = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "no strobe after enable", (cnt_chg - c0) + (cnt_dis - d0), 0);

        summary();
    end

endmodule